// File: doc/BRIEF.md
# Serial Handshake Data/Key Loader

This block sits in front of a small block-cipher engine and links it to an external host through one serial line in each direction. On the receive side, the controller issues a start command. The host then presents one bit per clock on the serial input, and it marks each valid bit with an input-ready line. The loader acknowledges each bit it takes. When a 128-bit word is complete, the loader raises a word-complete flag. A load command then moves the assembled word into either the data holding register or the key holding register, as a select input chooses.

On the transmit side, a send command captures a 128-bit result. The loader raises data-ready to the host and shifts the result out, most significant bit first. It moves one bit on every clock in which the host asserts its request. After the last bit leaves, data-ready drops and a one-cycle sent flag marks completion. All control inputs are synchronous to the clock, and so is the active-high reset.

Top module: `serial_loader`

## Requirements
- R1: After a synchronous reset, both holding registers are zero, and `word_ok`, `data_rdy`, `sent`, `rx_ack` and `ser_out` are all low.
- R2: Between `rx_start` and the 128th accepted bit, `rx_ack` follows `in_rdy` in the same cycle. At all other times it stays low.
- R3: Received bits are assembled MSB first: the first accepted bit becomes bit 127 of the word.
- R4: A cycle with `in_rdy` low accepts no bit, so stalls of any length leave the assembled word intact.
- R5: `word_ok` rises the cycle after the 128th bit is accepted. It stays high until the next `rx_start` or an accepted load. While it is high, `in_rdy` is not acknowledged and captures nothing.
- R6: An accepted `load_en` copies the assembled word into `key_reg` when `load_key` is 1, or into `data_reg` when `load_key` is 0. The new value is visible the next cycle, and the other register is unchanged.
- R7: `load_en` is ignored while a receive is in progress.
- R8: `tx_send` captures `tx_word`. From the next cycle, `data_rdy` is high and `ser_out` shows bit 127. Each cycle with `out_req` high advances by one bit, MSB first. Cycles with `out_req` low hold `ser_out`.
- R9: In the cycle after bit 0 is taken, `data_rdy` is low and `sent` is high for exactly one cycle.
- R10: `tx_send` while `data_rdy` is high is ignored.
- R11: `rx_start` during a receive restarts the count, so the next 128 accepted bits form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_start | input | 1 | Begin receiving a word |
| in_rdy | input | 1 | Host presents a valid bit on ser_in |
| ser_in | input | 1 | Serial input bit |
| rx_ack | output | 1 | Bit accepted this cycle |
| word_ok | output | 1 | A full word is assembled |
| load_en | input | 1 | Copy assembled word to a holding register |
| load_key | input | 1 | 1 selects key register, 0 selects data register |
| data_reg | output | 128 | Data holding register |
| key_reg | output | 128 | Key holding register |
| tx_send | input | 1 | Capture tx_word and start transmitting |
| tx_word | input | 128 | Result to transmit |
| out_req | input | 1 | Host takes the current ser_out bit |
| ser_out | output | 1 | Serial output bit |
| data_rdy | output | 1 | Transmission in progress |
| sent | output | 1 | One-cycle pulse after the last bit |

## Verification
The bench drives random words with random `in_rdy` and `out_req` gaps. A loader that counted idle cycles, or that reversed the bit order, would return a corrupted word. Directed cases cover the following:
- A restart partway through a word. A count that was not cleared would close the word early.
- A load during a receive. Without R7, a partial word would overwrite the key.
- Extra `in_rdy` pulses after completion. These would shift the finished word if not ignored.
- A second send during a transmission. This would corrupt the outgoing stream.

The timing of the final bit is also checked, since an off-by-one count moves `sent` and the fall of `data_rdy`.

// File: rtl/serial_loader.sv
module serial_loader #(
  parameter int W = 128,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_start,
  input  logic         in_rdy,
  input  logic         ser_in,
  output logic         rx_ack,
  output logic         word_ok,
  input  logic         load_en,
  input  logic         load_key,
  output logic [W-1:0] data_reg,
  output logic [W-1:0] key_reg,
  input  logic         tx_send,
  input  logic [W-1:0] tx_word,
  input  logic         out_req,
  output logic         ser_out,
  output logic         data_rdy,
  output logic         sent
);
  logic          rx_active, tx_active;
  logic [W-1:0]  rx_sh, tx_sh;
  logic [CW-1:0] rx_cnt, tx_cnt;

  wire rx_take = rx_active & in_rdy;
  wire tx_take = tx_active & out_req;
  wire load_ok = load_en & ~rx_active;

  assign rx_ack   = rx_take;
  assign ser_out  = tx_sh[W-1];
  assign data_rdy = tx_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_active <= 1'b0;
      rx_cnt    <= '0;
      rx_sh     <= '0;
      word_ok   <= 1'b0;
    end else if (rx_start) begin
      rx_active <= 1'b1;
      rx_cnt    <= '0;
      word_ok   <= 1'b0;
    end else if (rx_take) begin
      rx_sh  <= {rx_sh[W-2:0], ser_in};
      rx_cnt <= rx_cnt + 1'b1;
      if (rx_cnt == CW'(W-1)) begin
        rx_active <= 1'b0;
        word_ok   <= 1'b1;
      end
    end else if (load_ok) begin
      word_ok <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_reg <= '0;
      key_reg  <= '0;
    end else if (load_ok) begin
      if (load_key) key_reg  <= rx_sh;
      else          data_reg <= rx_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_active <= 1'b0;
      tx_cnt    <= '0;
      tx_sh     <= '0;
      sent      <= 1'b0;
    end else begin
      sent <= 1'b0;
      if (tx_send && !tx_active) begin
        tx_sh     <= tx_word;
        tx_active <= 1'b1;
        tx_cnt    <= '0;
      end else if (tx_take) begin
        tx_sh  <= {tx_sh[W-2:0], 1'b0};
        tx_cnt <= tx_cnt + 1'b1;
        if (tx_cnt == CW'(W-1)) begin
          tx_active <= 1'b0;
          sent      <= 1'b1;
        end
      end
    end
  end

  AST_ACK_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    rx_ack |-> !word_ok); // R5
  AST_ACK_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
    rx_ack |-> in_rdy); // R2
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(data_reg) && $stable(key_reg)); // R6
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (load_en && rx_active) |=> $stable(data_reg) && $stable(key_reg)); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (data_rdy && !out_req) |=> $stable(ser_out) && data_rdy); // R8
  AST_SENT_ONE: assert property (@(posedge clk) disable iff (rst)
    sent |=> !sent); // R9
  AST_SENT_IDLE: assert property (@(posedge clk) disable iff (rst)
    sent |-> !data_rdy && $past(data_rdy)); // R9
endmodule

// File: tb/serial_loader_tb_top.sv
`timescale 1ns/1ps
module serial_loader_tb_top;
  localparam int W = 128;
  logic clk = 0, rst = 1;
  logic rx_start = 0, in_rdy = 0, ser_in = 0, load_en = 0, load_key = 0;
  logic tx_send = 0, out_req = 0;
  logic [W-1:0] tx_word = '0;
  logic rx_ack, word_ok, ser_out, data_rdy, sent;
  logic [W-1:0] data_reg, key_reg;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  serial_loader #(.W(W)) dut_i (.*);

  function automatic logic [W-1:0] rnd_word();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // feed bits w[hi..lo] MSB first with random stalls; checks ack follows in_rdy (R2)
  task automatic feed(input logic [W-1:0] w, input int hi, input int lo, input bit do_start);
    bit ackbad = 0;
    if (do_start) begin
      @(negedge clk); rx_start = 1;
    end
    for (int i = hi; i >= lo; i--) begin
      bit r;
      do begin
        @(negedge clk);
        rx_start = 0;
        r = ($urandom % 3) != 0;
        in_rdy = r; ser_in = w[i];
        #1;
        if (rx_ack !== r) ackbad = 1;
      end while (!r);
    end
    @(negedge clk); in_rdy = 0;
    chk(!ackbad, "R2 ack follows in_rdy", W'(ackbad), '0);
  endtask

  task automatic do_load(input bit k);
    @(negedge clk); load_en = 1; load_key = k;
    @(negedge clk); load_en = 0;
  endtask

  task automatic transmit(input logic [W-1:0] w, input bit poke);
    logic [W-1:0] got = '0;
    bit rdybad = 0;
    @(negedge clk); tx_send = 1; tx_word = w;
    @(negedge clk); tx_send = 0; tx_word = ~w;
    for (int i = W - 1; i >= 0; i--) begin
      bit r;
      bit first = 1;
      do begin
        if (!first) @(negedge clk);
        first = 0;
        if (data_rdy !== 1'b1 || sent !== 1'b0) rdybad = 1;
        r = ($urandom % 2) != 0;
        out_req = r;
        tx_send = poke && (i == 64);
        if (r) got[i] = ser_out;
      end while (!r);
      @(negedge clk); out_req = 0; tx_send = 0;
      if (i == 0) begin end
    end
    chk(got === w, poke ? "R10 send while busy ignored" : "R8 serial out MSB first", got, w);
    chk(!rdybad, "R8 data_rdy held during transfer", W'(rdybad), '0);
    chk(data_rdy === 0 && sent === 1, "R9 end of transfer", {data_rdy, sent}, 2'b01);
    @(negedge clk);
    chk(sent === 0, "R9 sent single cycle", W'(sent), '0);
  endtask

  initial begin
    logic [W-1:0] a, b, c;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(data_reg === '0 && key_reg === '0, "R1 regs zero", data_reg | key_reg, '0);
    chk({word_ok, data_rdy, sent, rx_ack, ser_out} === 5'b0, "R1 flags low",
        {word_ok, data_rdy, sent, rx_ack, ser_out}, '0);

    for (int n = 0; n < 4; n++) begin
      a = rnd_word();
      feed(a, W - 1, 0, 1);
      chk(word_ok === 1, "R5 word_ok after 128 bits", W'(word_ok), 1);
      do_load(n[0]);
      chk((n[0] ? key_reg : data_reg) === a, "R3 R4 R6 word in register",
          n[0] ? key_reg : data_reg, a);
      chk(word_ok === 0, "R5 word_ok cleared by load", W'(word_ok), 0);
    end

    b = data_reg;
    a = rnd_word();
    feed(a, W - 1, 0, 1);
    do_load(1);
    chk(data_reg === b && key_reg === a, "R6 other register unchanged", data_reg, b);

    a = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
    feed(a, W - 1, 0, 1);
    @(negedge clk); in_rdy = 1; ser_in = 1; #1;
    chk(rx_ack === 0, "R5 in_rdy ignored when complete", W'(rx_ack), 0);
    repeat (3) @(negedge clk);
    in_rdy = 0;
    do_load(0);
    chk(data_reg === a, "R5 word not disturbed", data_reg, a);

    c = key_reg;
    a = rnd_word();
    feed(a, W - 1, 60, 1);
    do_load(1);
    chk(key_reg === c, "R7 load ignored during receive", key_reg, c);
    feed(a, 59, 0, 0);
    do_load(1);
    chk(key_reg === a, "R7 word after completion", key_reg, a);

    b = rnd_word();
    a = rnd_word();
    feed(b, W - 1, W - 50, 1);
    feed(a, W - 1, 0, 1);
    chk(word_ok === 1, "R11 restart completes", W'(word_ok), 1);
    do_load(0);
    chk(data_reg === a, "R11 restarted word", data_reg, a);

    transmit(128'h8000_0000_0000_0000_0000_0000_0000_0001, 0);
    for (int n = 0; n < 3; n++) transmit(rnd_word(), 0);
    transmit(rnd_word(), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule